// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins with its own small register set. Software sets the output value and the output-enable of every pin through registers. It reads back each pin's level after synchronization to the block clock. On the same path each pin can be armed as an interrupt source. The trigger is set by two bits per pin: a sensitivity bit chooses level or edge, and a polarity bit chooses low/falling or high/rising.

Edge events are held in a per-pin latch until software writes a one to that pin's bit in the end-of-interrupt register. Level sources simply follow the pin. The raw status is gated by the enable register. The masked status also removes masked pins. The single interrupt line is the OR of the masked status. A per-pin debounce filter can be switched in ahead of detection. A control bit chooses between a combinational and a registered interrupt line.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `pin_out_o` and `pin_oe_o` are zero and `irq_o` is low.
- R2: Writes to offset 0x00 set `pin_out_o`. Writes to offset 0x04 set `pin_oe_o`, where 1 means driven output and 0 means input. Both read back the written value.
- R3: A read of offset 0x50 returns the pin levels after a two-flop synchronizer. A pin change made just before a read is not yet visible in that read's data.
- R4: With type bit 0 (offset 0x38), a pin is level-sensitive. Polarity bit 1 (offset 0x3C) means active-high and 0 means active-low. Its raw status bit follows the active level, and an end-of-interrupt write does not clear it.
- R5: With type bit 1, a pin is edge-sensitive. Polarity 1 means rising and 0 means falling. A detected edge sets a latch that holds after the pin returns to its previous level.
- R6: Writing 1 to a bit at offset 0x4C clears that pin's edge latch, and writing 0 leaves it set. Offset 0x4C always reads zero.
- R7: A pin whose enable bit (offset 0x30) is 0 shows no raw status, and an edge seen while disabled is not latched.
- R8: Offset 0x44 returns the raw status. Offset 0x40 returns the raw status ANDed with the inverse of the mask at offset 0x34. With the registered mode off, `irq_o` is the OR of the masked status.
- R9: With a pin's debounce bit (offset 0x48) set, its filtered level changes only after the synchronized input has differed from it for DB_CYCLES consecutive clocks. Shorter pulses are dropped.
- R10: With bit 0 of offset 0x60 set, `irq_o` is registered and follows the masked status one clock later. With bit 0 clear, `irq_o` changes in the same cycle as the masked status.
- R11: Reads of an unmapped offset return zero, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| addr_i | input | 32 | Register byte address |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe; data appears on rdata_o after the next clock |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | NPINS | External pin levels, asynchronous |
| pin_out_o | output | NPINS | Output values for the pads |
| pin_oe_o | output | NPINS | Output enables for the pads |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Random phases use a random enable, mask, type and polarity setup for all pins. They drive random pin vectors with random end-of-interrupt writes in between, so all four triggers and both masked and unmasked pins are mixed in every read. Directed cases separate behaviours that look alike:
- a level source against a latched edge under an end-of-interrupt write;
- a write of zero against a write of one to end-of-interrupt;
- an edge while disabled against one while enabled;
- a debounce pulse just shorter than the window against one that is long enough;
- the same unmask write seen one cycle apart in the two interrupt modes.

A read made right after a pin change shows whether the synchronizer has two stages.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and types for the GPIO interrupt bank.
// Assumes a byte-addressed window decoded on its low eight address bits.
package gpio_irq_pkg;

    localparam int unsigned OFS_W = 8;

    // Register offsets; software decodes these, so they are fixed.
    localparam logic [OFS_W-1:0] OFS_DOUT  = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DIR   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_IEN   = 8'h30;
    localparam logic [OFS_W-1:0] OFS_IMSK  = 8'h34;
    localparam logic [OFS_W-1:0] OFS_TYPE  = 8'h38;
    localparam logic [OFS_W-1:0] OFS_POL   = 8'h3C;
    localparam logic [OFS_W-1:0] OFS_MSTAT = 8'h40;
    localparam logic [OFS_W-1:0] OFS_RAW   = 8'h44;
    localparam logic [OFS_W-1:0] OFS_DBEN  = 8'h48;
    localparam logic [OFS_W-1:0] OFS_EOI   = 8'h4C;
    localparam logic [OFS_W-1:0] OFS_PINS  = 8'h50;
    localparam logic [OFS_W-1:0] OFS_LSYNC = 8'h60;

    // Trigger kind, encoded as {polarity bit, type bit}.
    typedef enum logic [1:0] {
        TRIG_LOW_LEVEL  = 2'b00,
        TRIG_FALL_EDGE  = 2'b01,
        TRIG_HIGH_LEVEL = 2'b10,
        TRIG_RISE_EDGE  = 2'b11
    } trig_e;

endpackage

// File: rtl/gpio_pin_filter.sv
// Input conditioning for the GPIO bank: a two-flop synchronizer on every
// pin, then an optional per-pin debounce filter.
// Assumes: pin_i is asynchronous; DB_CYCLES >= 1.
module gpio_pin_filter #(
    parameter int unsigned NPINS     = 32,
    parameter int unsigned DB_CYCLES = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] db_en_i,
    output logic [NPINS-1:0] level_o
);

    localparam int unsigned CNT_W = (DB_CYCLES < 2) ? 1 : $clog2(DB_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;

    // Two-stage synchronizer into the block clock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    for (genvar k = 0; k < NPINS; k++) begin : g_pin
        logic [CNT_W-1:0] cnt_q;
        logic             hold_q;

        // Debounce: accept a new level only after it has persisted.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                cnt_q  <= '0;
                hold_q <= 1'b0;
            end else if (!db_en_i[k] || (sync_q[k] == hold_q)) begin
                cnt_q  <= '0;
                hold_q <= db_en_i[k] ? hold_q : sync_q[k];
            end else if (cnt_q == CNT_LAST) begin
                cnt_q  <= '0;
                hold_q <= sync_q[k];
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end

        assign level_o[k] = db_en_i[k] ? hold_q : sync_q[k];

        // A filtered level may only move at the end of a full window.
        assert_db_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (db_en_i[k] && $past(db_en_i[k]) && (hold_q != $past(hold_q)))
            |-> ($past(cnt_q) == CNT_LAST));
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin interrupt detection: level tracking, edge detection and the
// edge latch cleared by end-of-interrupt.
// Assumes level_i is already synchronous to clk_i.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] level_i,
    input  logic [NPINS-1:0] ien_i,
    input  logic [NPINS-1:0] type_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] eoi_i,
    output logic [NPINS-1:0] raw_o
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] edge_set;
    logic [NPINS-1:0] lvl_act;

    // Previous filtered sample, used for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= level_i;
    end

    for (genvar k = 0; k < NPINS; k++) begin : g_det
        // Decode the trigger kind into edge hit and active level.
        always_comb begin
            edge_set[k] = 1'b0;
            lvl_act[k]  = 1'b0;
            case (trig_e'({pol_i[k], type_i[k]}))
                TRIG_LOW_LEVEL:  lvl_act[k]  = ~level_i[k];
                TRIG_HIGH_LEVEL: lvl_act[k]  = level_i[k];
                TRIG_FALL_EDGE:  edge_set[k] = ien_i[k] & prev_q[k] & ~level_i[k];
                TRIG_RISE_EDGE:  edge_set[k] = ien_i[k] & ~prev_q[k] & level_i[k];
                default:         lvl_act[k]  = 1'b0;
            endcase
        end

        // Edge latch: a new edge wins over a clear in the same cycle.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)          latch_q[k] <= 1'b0;
            else if (edge_set[k]) latch_q[k] <= 1'b1;
            else if (eoi_i[k])    latch_q[k] <= 1'b0;
        end

        assign raw_o[k] = ien_i[k] & (type_i[k] ? latch_q[k] : lvl_act[k]);
    end

    // A cleared latch stays clear unless a new edge arrived.
    assert_eoi_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_i != '0) |=> ((latch_q & $past(eoi_i & ~edge_set)) == '0));

    // A disabled pin never reports.
    assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((raw_o & ~ien_i) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: register file, read mux and combined interrupt line.
// Assumes: one-cycle wr_en_i/rd_en_i strobes; NPINS <= 32; offsets decoded
// on addr_i[7:0], upper address bits belong to the enclosing fabric.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS     = 32,
    parameter int unsigned DB_CYCLES = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [31:0]      addr_i,
    input  logic [31:0]      wdata_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    output logic [31:0]      rdata_o,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] pin_out_o,
    output logic [NPINS-1:0] pin_oe_o,
    output logic             irq_o
);

    logic [OFS_W-1:0] ofs;
    logic [NPINS-1:0] wval;
    logic [NPINS-1:0] dout_q, dir_q, ien_q, imsk_q, type_q, pol_q, dben_q;
    logic             lsync_q;
    logic [NPINS-1:0] eoi;
    logic [NPINS-1:0] level;
    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] mstat;
    logic             irq_comb;
    logic             irq_q;
    logic [31:0]      rd_mux;

    assign ofs  = addr_i[OFS_W-1:0];
    assign wval = wdata_i[NPINS-1:0];

    // Software-written configuration registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dout_q  <= '0;
            dir_q   <= '0;
            ien_q   <= '0;
            imsk_q  <= '0;
            type_q  <= '0;
            pol_q   <= '0;
            dben_q  <= '0;
            lsync_q <= 1'b0;
        end else if (wr_en_i) begin
            case (ofs)
                OFS_DOUT:  dout_q  <= wval;
                OFS_DIR:   dir_q   <= wval;
                OFS_IEN:   ien_q   <= wval;
                OFS_IMSK:  imsk_q  <= wval;
                OFS_TYPE:  type_q  <= wval;
                OFS_POL:   pol_q   <= wval;
                OFS_DBEN:  dben_q  <= wval;
                OFS_LSYNC: lsync_q <= wdata_i[0];
                default:   ;
            endcase
        end
    end

    // End-of-interrupt is a write pulse, never stored.
    assign eoi = (wr_en_i && (ofs == OFS_EOI)) ? wval : '0;

    gpio_pin_filter #(
        .NPINS     (NPINS),
        .DB_CYCLES (DB_CYCLES)
    ) u_filter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i),
        .db_en_i (dben_q),
        .level_o (level)
    );

    gpio_irq_detect #(
        .NPINS (NPINS)
    ) u_detect (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (level),
        .ien_i   (ien_q),
        .type_i  (type_q),
        .pol_i   (pol_q),
        .eoi_i   (eoi),
        .raw_o   (raw)
    );

    assign mstat    = raw & ~imsk_q;
    assign irq_comb = |mstat;

    // Optional register stage on the interrupt line.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= irq_comb;
    end

    assign irq_o = lsync_q ? irq_q : irq_comb;

    // Read data select; unmapped and end-of-interrupt offsets give zero.
    always_comb begin
        case (ofs)
            OFS_DOUT:  rd_mux = 32'(dout_q);
            OFS_DIR:   rd_mux = 32'(dir_q);
            OFS_IEN:   rd_mux = 32'(ien_q);
            OFS_IMSK:  rd_mux = 32'(imsk_q);
            OFS_TYPE:  rd_mux = 32'(type_q);
            OFS_POL:   rd_mux = 32'(pol_q);
            OFS_MSTAT: rd_mux = 32'(mstat);
            OFS_RAW:   rd_mux = 32'(raw);
            OFS_DBEN:  rd_mux = 32'(dben_q);
            OFS_PINS:  rd_mux = 32'(level);
            OFS_LSYNC: rd_mux = {31'd0, lsync_q};
            default:   rd_mux = '0;
        endcase
    end

    // Registered read port.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_mux;
    end

    assign pin_out_o = dout_q;
    assign pin_oe_o  = dir_q;

    assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (ofs == OFS_DIR)) |=> (pin_oe_o == $past(wval)));

    assert_eoi_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && (ofs == OFS_EOI)) |=> (rdata_o == 32'd0));

    assert_masked_subset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mstat & imsk_q) == '0));

    assert_irq_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lsync_q && $past(lsync_q)) |-> (irq_o == $past(irq_comb)));

endmodule

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;

    localparam int NP = 32;
    localparam int DB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [31:0]   rdata;
    logic [NP-1:0] pins = '0;
    logic [NP-1:0] pout, poe;
    logic          irq;

    int n_checks = 0;
    int n_errors = 0;

    // Bench model state
    logic [NP-1:0] m_en, m_msk, m_typ, m_pol, m_latch, m_prev;

    always #5 clk = ~clk;

    gpio_irq_bank #(.NPINS(NP), .DB_CYCLES(DB)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .pin_i(pins),
        .pin_out_o(pout), .pin_oe_o(poe), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = {24'd0, a}; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = {24'd0, a}; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected raw status from the bench model and the current pins.
    function automatic logic [NP-1:0] exp_raw(input logic [NP-1:0] p);
        logic [NP-1:0] lvl;
        lvl = m_pol & p | ~m_pol & ~p;
        return m_en & ((m_typ & m_latch) | (~m_typ & lvl));
    endfunction

    // Advance the model edge latches for a pin change.
    function automatic logic [NP-1:0] next_latch(input logic [NP-1:0] o, input logic [NP-1:0] n);
        logic [NP-1:0] rise, fall;
        rise = ~o & n;
        fall = o & ~n;
        return m_latch | (m_en & m_typ & ((m_pol & rise) | (~m_pol & fall)));
    endfunction

    task automatic drive(input logic [NP-1:0] p);
        @(negedge clk);
        m_latch = next_latch(m_prev, p);
        m_prev  = p;
        pins    = p;
        settle(6);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        void'($urandom(32'h5eed_1234));
        m_en = '0; m_msk = '0; m_typ = '0; m_pol = '0; m_latch = '0; m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(2);

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 pin_out", pout, 32'd0);
        chk("R1 pin_oe", poe, 32'd0);
        foreach (v2[i]) begin end
        rd(8'h00, v); chk("R1 dout", v, 0);
        rd(8'h30, v); chk("R1 ien", v, 0);
        rd(8'h38, v); chk("R1 type", v, 0);
        rd(8'h44, v); chk("R1 raw", v, 0);
        rd(8'h60, v); chk("R1 lsync", v, 0);

        // R2 output and direction
        wr(8'h00, 32'hA5A5_0F0F);
        chk("R2 pin_out", pout, 32'hA5A5_0F0F);
        rd(8'h00, v); chk("R2 dout readback", v, 32'hA5A5_0F0F);
        wr(8'h04, 32'hFFFF_0000);
        chk("R2 pin_oe", poe, 32'hFFFF_0000);
        rd(8'h04, v); chk("R2 dir readback", v, 32'hFFFF_0000);

        // R11 unmapped offset
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h00, v); chk("R11 write ignored", v, 32'hA5A5_0F0F);
        rd(8'h20, v); chk("R11 read zero", v, 0);

        // R3 two-flop synchronizer
        @(negedge clk); pins = 32'h1234_5678; m_prev = pins;
        rd(8'h50, v); chk("R3 not yet visible", v, 0);
        rd(8'h50, v); chk("R3 synced level", v, 32'h1234_5678);
        @(negedge clk); pins = '0; m_prev = '0; settle(4);

        // R4 level triggers: pin 4 active-high, pin 5 active-low
        m_en = 32'h30; m_typ = '0; m_pol = 32'h10;
        wr(8'h3C, m_pol); wr(8'h38, m_typ); wr(8'h30, m_en);
        rd(8'h44, v); chk("R4 low-level pin5 active", v, 32'h20);
        drive(32'h10);
        rd(8'h44, v); chk("R4 both active", v, 32'h30);
        wr(8'h4C, 32'h30);
        rd(8'h44, v); chk("R4 eoi does not clear level", v, 32'h30);
        drive(32'h20);
        rd(8'h44, v); chk("R4 both inactive", v, 0);
        drive('0);

        // R5/R6 edges: pin 8 rising, pin 9 falling
        m_en = 32'h300; m_typ = 32'h300; m_pol = 32'h100;
        wr(8'h3C, m_pol); wr(8'h38, m_typ); wr(8'h30, m_en);
        wr(8'h4C, 32'hFFFF_FFFF); m_latch = '0;
        drive(32'h100);
        drive(32'h000);
        rd(8'h44, v); chk("R5 rising latched after return", v, 32'h100);
        wr(8'h4C, 32'h0000_00FF);
        rd(8'h44, v); chk("R6 eoi zero bit no effect", v, 32'h100);
        wr(8'h4C, 32'h100); m_latch = '0;
        rd(8'h44, v); chk("R6 eoi clears", v, 0);
        rd(8'h4C, v); chk("R6 eoi reads zero", v, 0);
        drive(32'h200);
        rd(8'h44, v); chk("R5 no falling yet", v, 0);
        drive(32'h000);
        rd(8'h44, v); chk("R5 falling latched", v, 32'h200);
        wr(8'h4C, 32'h200); m_latch = '0;

        // R7 disabled edge is not latched
        m_en = '0; wr(8'h30, '0);
        drive(32'h100); drive(32'h000);
        rd(8'h44, v); chk("R7 disabled raw", v, 0);
        m_en = 32'h300; wr(8'h30, m_en);
        rd(8'h44, v); chk("R7 no stale latch", v, 0);

        // R8 mask and combined line
        drive(32'h100);
        rd(8'h40, v); chk("R8 masked unmasked", v, 32'h100);
        chk("R8 irq high", {31'd0, irq}, 1);
        m_msk = 32'h100; wr(8'h34, m_msk);
        rd(8'h40, v); chk("R8 masked hidden", v, 0);
        rd(8'h44, v); chk("R8 raw still set", v, 32'h100);
        chk("R8 irq low", {31'd0, irq}, 0);

        // R10 registered line: unmask and watch the cycle irq rises
        wr(8'h60, 32'h1);
        settle(2);
        wr(8'h34, '0);
        chk("R10 irq one cycle late", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R10 irq after delay", {31'd0, irq}, 1);
        wr(8'h60, 32'h0);
        wr(8'h34, 32'h100);
        chk("R10 combinational drop", {31'd0, irq}, 0);
        wr(8'h34, '0); m_msk = '0;
        wr(8'h4C, 32'hFFFF_FFFF); m_latch = '0;
        drive('0);
        wr(8'h4C, 32'hFFFF_FFFF); m_latch = '0;

        // R9 debounce on pin 0
        wr(8'h48, 32'h1);
        @(negedge clk); pins = 32'h1;
        settle(3);
        @(negedge clk); pins = 32'h0;
        settle(DB + 4);
        rd(8'h50, v); chk("R9 short pulse dropped", v, 0);
        @(negedge clk); pins = 32'h1;
        settle(DB - 3);
        rd(8'h50, v); chk("R9 not before window", v, 0);
        settle(6);
        rd(8'h50, v); chk("R9 after window", v, 1);
        wr(8'h48, 32'h0);
        @(negedge clk); pins = '0; settle(6);
        m_prev = '0;
        wr(8'h4C, 32'hFFFF_FFFF); m_latch = '0;

        // Random phases, all four triggers mixed (R4 R5 R6 R7 R8)
        for (int r = 0; r < 4; r++) begin
            m_en = $urandom; m_msk = $urandom; m_typ = $urandom; m_pol = $urandom;
            wr(8'h3C, m_pol); wr(8'h38, m_typ); wr(8'h34, m_msk); wr(8'h30, m_en);
            wr(8'h4C, 32'hFFFF_FFFF); m_latch = '0;
            for (int s = 0; s < 30; s++) begin
                logic [NP-1:0] e;
                drive($urandom);
                if ($urandom_range(0, 2) == 0) begin
                    e = $urandom;
                    wr(8'h4C, e);
                    m_latch = m_latch & ~e;
                end
                rd(8'h44, v); chk("R5 random raw", v, exp_raw(m_prev));
                rd(8'h40, v); chk("R8 random masked", v, exp_raw(m_prev) & ~m_msk);
                chk("R8 random irq", {31'd0, irq}, {31'd0, |(exp_raw(m_prev) & ~m_msk)});
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule